// File: doc/BRIEF.md
# Power Unit Command Register Block

This block is the software-facing register file of a power management unit that governs 64 logical subsystems, each with a 2-bit power state. Software programs the wanted states into four state-control words and then writes a set-configuration command. The block accepts the command, reports busy for a fixed, parameterised number of cycles, and then copies the control words into the four state-status words. It also drives the applied states on a flat output vector and raises a completion cause in its interrupt register.

Until a command completes, the readable state-status words lag the written control words. An interrupt line follows the pending flag, gated by an enable bit. Two wake-configuration words are plain read/write storage; the wake-status words read as zero. Access is a single-cycle 32-bit bus: a write takes effect at the clock edge where `bus_sel` and `bus_we` are high, and `bus_rdata` is combinational from `bus_addr`. Accesses whose address is not word aligned are ignored and read zero.

Top module: `pwr_unit`

## Requirements
- R1: After reset every register reads zero, busy (status bit 8) and pending (interrupt bit 9) are clear, `irq` is low and `subsys_pwr` is zero.
- R2: State-control words (byte 0x20 + 4n, n = 0..3) and wake-configuration words (0x10 + 4n, n = 0..1) read back what was written, including all ones. Writes to status (0x00), wake status (0x18/0x1C) and state status (0x30 + 4n) change nothing.
- R3: A command write (0x04) with code bits 7:0 = 0x01 and mode bits 10:9 = 1 sets busy for exactly BUSY_CYCLES cycles, starting the cycle after the write.
- R4: State-status words and `subsys_pwr` stay unchanged while busy. When busy clears they equal the state-control words held at that moment.
- R5: At completion, the cause field (interrupt bits 7:0) becomes 1 and pending is set.
- R6: `irq` is high exactly when pending and the enable bit (interrupt bit 8) are both 1.
- R7: Writing 1 to interrupt bit 9 clears pending; writing 0 there leaves it. A completion at the same edge as the clear leaves pending set.
- R8: A command with a non-zero mode and a code other than 0x01 does not set busy or change the state words. It sets cause 2 and pending at the next edge.
- R9: A command with mode 0 (no-op) sets no busy or pending and changes no state word. The command word still reads back the value written.
- R10: A command write while busy is ignored: the command word keeps its value, and the running command finishes with cause 1.
- R11: Modes 2 (delayed) and 3 (triggered) with code 0x01 run the same busy-then-apply sequence as mode 1.
- R12: Subsystem k occupies state word k/16 at bits 2(k%16)+1 : 2(k%16), and `subsys_pwr[2k+1:2k]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe |
| bus_we | input | 1 | Write when 1, read when 0 |
| bus_addr | input | ADDR_W (8) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq | output | 1 | Interrupt request, pending gated by enable |
| subsys_pwr | output | 2*N_SUBSYS (128) | Applied power state of every subsystem |

## Verification
The assertions check on every cycle that a command arriving while busy leaves the command word untouched, and that the state-status words move only on a completion. They also check that a completion or a rejected code leaves the right cause with pending set, that a clear write drops pending, and that busy can only rise after an accepted set-configuration command. Some behaviour only the bench scenarios can show: the exact busy length, where a given subsystem sits in the state vector, that a completion wins over a clear at the same edge, the enable gating of `irq`, and the read-back of every register.

// File: rtl/pwr_unit_pkg.sv
package pwr_unit_pkg;
  // Word indices (byte offset / 4); software depends on this map.
  localparam int W_STS = 0;
  localparam int W_CMD = 1;
  localparam int W_ICS = 2;
  localparam int W_WKC = 4;
  localparam int W_SSC = 8;
  localparam int W_SSS = 12;

  localparam int BIT_BUSY = 8;
  localparam int BIT_IE   = 8;
  localparam int BIT_PEND = 9;

  localparam logic [7:0] CODE_SET_CFG = 8'h01;

  typedef enum logic [1:0] {
    MODE_NOP  = 2'd0,
    MODE_IMM  = 2'd1,
    MODE_DLY  = 2'd2,
    MODE_TRIG = 2'd3
  } cmd_mode_e;

  typedef enum logic [7:0] {
    CAUSE_NONE      = 8'd0,
    CAUSE_DONE      = 8'd1,
    CAUSE_CMD_ERR   = 8'd2,
    CAUSE_WAKE      = 8'd3,
    CAUSE_PWR_ERR   = 8'd4,
    CAUSE_MSG_ERR   = 8'd5,
    CAUSE_NO_DEEP   = 8'd6,
    CAUSE_TRIG_ERR  = 8'd7,
    CAUSE_IDLE      = 8'd8
  } cause_e;
endpackage

// File: rtl/pwr_unit_seq.sv
module pwr_unit_seq #(
  parameter int BUSY_CYCLES = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CNT_W = (BUSY_CYCLES < 2) ? 1 : $clog2(BUSY_CYCLES);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_W'(BUSY_CYCLES - 1);
    end
  end

  assign busy = busy_q;
  assign done = busy_q && (cnt_q == '0);
endmodule

// File: rtl/pwr_unit_irq.sv
module pwr_unit_irq
  import pwr_unit_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_done,
  input  logic       set_err,
  input  logic       ics_wr,
  input  logic       wr_ie,
  input  logic       wr_pend,
  output logic [7:0] cause,
  output logic       pend,
  output logic       ie,
  output logic       irq
);
  cause_e cause_q;
  logic   pend_q;
  logic   ie_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= CAUSE_NONE;
      pend_q  <= 1'b0;
      ie_q    <= 1'b0;
    end else begin
      if (set_done)     cause_q <= CAUSE_DONE;
      else if (set_err) cause_q <= CAUSE_CMD_ERR;

      if (set_done || set_err)  pend_q <= 1'b1;
      else if (ics_wr && wr_pend) pend_q <= 1'b0;

      if (ics_wr) ie_q <= wr_ie;
    end
  end

  assign cause = cause_q;
  assign pend  = pend_q;
  assign ie    = ie_q;
  assign irq   = pend_q & ie_q;
endmodule

// File: rtl/pwr_unit_bank.sv
module pwr_unit_bank #(
  parameter int N = 4,
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   wr_vec,
  input  logic [W-1:0]   wdata,
  input  logic           load,
  input  logic [N*W-1:0] load_data,
  output logic [N*W-1:0] q
);
  for (genvar g = 0; g < N; g++) begin : g_word
    logic [W-1:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         word_q <= '0;
      else if (load)      word_q <= load_data[g*W +: W];
      else if (wr_vec[g]) word_q <= wdata;
    end
    assign q[g*W +: W] = word_q;
  end
endmodule

// File: rtl/pwr_unit.sv
module pwr_unit
  import pwr_unit_pkg::*;
#(
  parameter int N_SUBSYS    = 64,
  parameter int ADDR_W      = 8,
  parameter int BUSY_CYCLES = 6,
  parameter int N_WAKE_REGS = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_sel,
  input  logic                  bus_we,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  output logic                  irq,
  output logic [2*N_SUBSYS-1:0] subsys_pwr
);
  localparam int SS_BITS   = 2 * N_SUBSYS;
  localparam int N_SS_REGS = SS_BITS / 32;

  int        widx;
  logic      aligned;
  logic      wr;
  logic      cmd_hit, ics_hit, cmd_acc;
  logic      start, bad_cmd;
  logic      busy, done;
  logic      pend, ie;
  logic [7:0] cause;
  logic [31:0] cmd_q;
  cmd_mode_e mode;
  logic [N_WAKE_REGS-1:0]    wkc_wr;
  logic [N_SS_REGS-1:0]      ssc_wr;
  logic [32*N_WAKE_REGS-1:0] wkc_flat;
  logic [SS_BITS-1:0]        ssc_flat;
  logic [SS_BITS-1:0]        sss_flat;
  logic                      ics_clr;

  assign aligned = (bus_addr[1:0] == 2'b00);
  assign widx    = int'(bus_addr[ADDR_W-1:2]);
  assign wr      = bus_sel && bus_we && aligned;
  assign cmd_hit = wr && (widx == W_CMD);
  assign ics_hit = wr && (widx == W_ICS);
  assign ics_clr = ics_hit && bus_wdata[BIT_PEND];
  assign cmd_acc = cmd_hit && !busy;
  assign mode    = cmd_mode_e'(bus_wdata[10:9]);
  assign start   = cmd_acc && (mode != MODE_NOP) && (bus_wdata[7:0] == CODE_SET_CFG);
  assign bad_cmd = cmd_acc && (mode != MODE_NOP) && (bus_wdata[7:0] != CODE_SET_CFG);

  for (genvar g = 0; g < N_WAKE_REGS; g++) begin : g_wkc_dec
    assign wkc_wr[g] = wr && (widx == W_WKC + g);
  end
  for (genvar g = 0; g < N_SS_REGS; g++) begin : g_ssc_dec
    assign ssc_wr[g] = wr && (widx == W_SSC + g);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cmd_q <= '0;
    else if (cmd_acc) cmd_q <= bus_wdata;
  end

  pwr_unit_seq #(.BUSY_CYCLES(BUSY_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done)
  );

  pwr_unit_irq u_irq (
    .clk(clk), .rst_n(rst_n), .set_done(done), .set_err(bad_cmd),
    .ics_wr(ics_hit), .wr_ie(bus_wdata[BIT_IE]), .wr_pend(bus_wdata[BIT_PEND]),
    .cause(cause), .pend(pend), .ie(ie), .irq(irq)
  );

  pwr_unit_bank #(.N(N_WAKE_REGS), .W(32)) u_wkc (
    .clk(clk), .rst_n(rst_n), .wr_vec(wkc_wr), .wdata(bus_wdata),
    .load(1'b0), .load_data('0), .q(wkc_flat)
  );

  pwr_unit_bank #(.N(N_SS_REGS), .W(32)) u_ssc (
    .clk(clk), .rst_n(rst_n), .wr_vec(ssc_wr), .wdata(bus_wdata),
    .load(1'b0), .load_data('0), .q(ssc_flat)
  );

  pwr_unit_bank #(.N(N_SS_REGS), .W(32)) u_sss (
    .clk(clk), .rst_n(rst_n), .wr_vec('0), .wdata(bus_wdata),
    .load(done), .load_data(ssc_flat), .q(sss_flat)
  );

  assign subsys_pwr = sss_flat;

  always_comb begin
    bus_rdata = '0;
    if (aligned) begin
      if (widx == W_STS) bus_rdata[BIT_BUSY] = busy;
      if (widx == W_CMD) bus_rdata = cmd_q;
      if (widx == W_ICS) begin
        bus_rdata[7:0]      = cause;
        bus_rdata[BIT_IE]   = ie;
        bus_rdata[BIT_PEND] = pend;
      end
      for (int i = 0; i < N_WAKE_REGS; i++)
        if (widx == W_WKC + i) bus_rdata = wkc_flat[i*32 +: 32];
      for (int i = 0; i < N_SS_REGS; i++) begin
        if (widx == W_SSC + i) bus_rdata = ssc_flat[i*32 +: 32];
        if (widx == W_SSS + i) bus_rdata = sss_flat[i*32 +: 32];
      end
    end
  end
endmodule

// File: rtl/pwr_unit_chk.sv
module pwr_unit_chk #(
  parameter int SSW = 128
) (
  input logic           clk,
  input logic           rst_n,
  input logic           busy,
  input logic           done,
  input logic           cmd_hit,
  input logic [31:0]    wdata,
  input logic [31:0]    cmd_q,
  input logic [SSW-1:0] sss,
  input logic           pend,
  input logic [7:0]     cause,
  input logic           ics_clr
);
  assert_cmd_ignored_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cmd_hit |=> $stable(cmd_q));

  assert_status_moves_on_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(sss));

  assert_done_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> pend && (cause == 8'd1));

  assert_clear_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ics_clr && !done |=> !pend);

  assert_busy_origin_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_hit && (wdata[7:0] == 8'h01) && (wdata[10:9] != 2'd0)));

  assert_bad_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_hit && !busy && (wdata[10:9] != 2'd0) && (wdata[7:0] != 8'h01)
    |=> !busy && (cause == 8'd2) && pend);

  assert_nop_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_hit && !busy && (wdata[10:9] == 2'd0) |=> !busy);
endmodule

bind pwr_unit pwr_unit_chk #(.SSW(2*N_SUBSYS)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .cmd_hit(cmd_hit),
  .wdata(bus_wdata), .cmd_q(cmd_q), .sss(sss_flat), .pend(pend),
  .cause(cause), .ics_clr(ics_clr)
);

// File: tb/pwr_unit_test.sv
`timescale 1ns/100ps
module pwr_unit_test;
  localparam int BUSY = 6;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_sel = 1'b0, bus_we = 1'b0;
  logic [7:0]   bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic         irq;
  logic [127:0] subsys_pwr;

  int checks = 0, failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  pwr_unit #(.BUSY_CYCLES(BUSY)) uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .subsys_pwr(subsys_pwr)
  );

  // Behavioural reference model
  logic [31:0] m_ssc [4];
  logic [31:0] m_sss [4];
  logic [31:0] m_wkc [2];
  logic [31:0] m_cmd;
  bit          m_busy, m_pend, m_ie;
  int          m_cnt;
  logic [7:0]  m_cause;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_ssc[i]) begin m_ssc[i] = 0; m_sss[i] = 0; end
      foreach (m_wkc[i]) m_wkc[i] = 0;
      m_cmd = 0; m_busy = 0; m_pend = 0; m_ie = 0; m_cnt = 0; m_cause = 0;
    end else begin
      bit was_busy, set_p, clr_p;
      was_busy = m_busy; set_p = 0; clr_p = 0;
      if (m_busy) begin
        if (m_cnt == 0) begin
          m_busy = 0; m_sss = m_ssc; m_cause = 1; set_p = 1;
        end else m_cnt--;
      end
      if (bus_sel && bus_we && bus_addr[1:0] == 0) begin
        case (bus_addr)
          8'h04: if (!was_busy) begin
            m_cmd = bus_wdata;
            if (bus_wdata[10:9] != 0) begin
              if (bus_wdata[7:0] == 8'h01) begin m_busy = 1; m_cnt = BUSY - 1; end
              else begin m_cause = 2; set_p = 1; end
            end
          end
          8'h08: begin m_ie = bus_wdata[8]; clr_p = bus_wdata[9]; end
          8'h10, 8'h14: m_wkc[(bus_addr - 8'h10) / 4] = bus_wdata;
          8'h20, 8'h24, 8'h28, 8'h2C: m_ssc[(bus_addr - 8'h20) / 4] = bus_wdata;
          default: ;
        endcase
      end
      if (set_p) m_pend = 1; else if (clr_p) m_pend = 0;
    end
  end

  function automatic logic [31:0] m_read(logic [7:0] a);
    if (a[1:0] != 0) return 0;
    case (a)
      8'h00: return {23'b0, m_busy, 8'b0};
      8'h04: return m_cmd;
      8'h08: return {22'b0, m_pend, m_ie, m_cause};
      8'h10, 8'h14: return m_wkc[(a - 8'h10) / 4];
      8'h20, 8'h24, 8'h28, 8'h2C: return m_ssc[(a - 8'h20) / 4];
      8'h30, 8'h34, 8'h38, 8'h3C: return m_sss[(a - 8'h30) / 4];
      default: return 0;
    endcase
  endfunction

  task automatic check(string req, logic [127:0] got, logic [127:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  // Per-cycle comparison of outputs that depend on state only
  always @(negedge clk) if (rst_n && !finished) begin
    check("R6 irq per cycle", {127'b0, irq}, {127'b0, m_pend & m_ie});
    check("R4 subsys_pwr per cycle", subsys_pwr, {m_sss[3], m_sss[2], m_sss[1], m_sss[0]});
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(string req, logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    #1 v = bus_rdata;
    check(req, {96'b0, v}, {96'b0, m_read(a)});
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 100 && m_busy; i++) @(negedge clk);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset values
    foreach (uut.bus_rdata[i]) ; // no-op keeps loop structure simple
    for (int a = 0; a < 64; a += 4) begin
      rd("R1 reset read", 8'(a), v);
      check("R1 reset zero", {96'b0, v}, 128'b0);
    end
    check("R1 irq low", {127'b0, irq}, 128'b0);

    // R2: read/write and ignored writes
    wr(8'h20, 32'hF00F_FFFF); wr(8'h24, 32'h1234_5678);
    wr(8'h28, 32'hA5A5_0000); wr(8'h2C, 32'hFFFF_FFFF);
    wr(8'h10, 32'hFFFF_FFFF); wr(8'h14, 32'hFFFF_FFFF);
    wr(8'h00, 32'hFFFF_FFFF); wr(8'h18, 32'hFFFF_FFFF); wr(8'h30, 32'hDEAD_BEEF);
    wr(8'h21, 32'h0000_0000);
    rd("R2 ssc0", 8'h20, v); check("R2 ssc0 value", {96'b0, v}, {96'b0, 32'hF00F_FFFF});
    rd("R2 ssc3", 8'h2C, v);
    rd("R2 wkc0", 8'h10, v); check("R2 wake all ones", {96'b0, v}, {96'b0, 32'hFFFF_FFFF});
    rd("R2 wkc1", 8'h14, v);
    rd("R2 status ignored", 8'h00, v); check("R2 status zero", {96'b0, v}, 128'b0);
    rd("R2 wks ignored", 8'h18, v);
    rd("R2 sss ignored", 8'h30, v); check("R2 sss zero", {96'b0, v}, 128'b0);

    // R9: no-op mode
    wr(8'h04, 32'h0000_0001);
    rd("R9 status", 8'h00, v); check("R9 no busy", {127'b0, v[8]}, 128'b0);
    rd("R9 cmd readback", 8'h04, v); check("R9 cmd value", {96'b0, v}, {96'b0, 32'h1});
    rd("R9 ics", 8'h08, v); check("R9 no pending", {127'b0, v[9]}, 128'b0);
    rd("R9 sss", 8'h30, v);

    // R3/R4/R5/R6: immediate set-config with interrupt enabled
    wr(8'h08, 32'h0000_0100);
    wr(8'h04, 32'h0000_0201);
    n = 0;
    for (int i = 0; i < 100; i++) begin
      rd("R3 status poll", 8'h00, v);
      if (v[8]) begin
        n++;
        if (n == 2) begin
          logic [31:0] s;
          rd("R4 sss lag", 8'h30, s);
          check("R4 sss unchanged while busy", {96'b0, s}, 128'b0);
          n++;
        end
      end else break;
    end
    check("R3 busy length", n, BUSY);
    rd("R4 sss0 applied", 8'h30, v); check("R4 sss0", {96'b0, v}, {96'b0, 32'hF00F_FFFF});
    rd("R4 sss1 applied", 8'h34, v); check("R4 sss1", {96'b0, v}, {96'b0, 32'h1234_5678});
    rd("R5 ics", 8'h08, v);
    check("R5 cause done", {120'b0, v[7:0]}, 128'd1);
    check("R5 pending", {127'b0, v[9]}, 128'd1);
    check("R6 irq high", {127'b0, irq}, 128'd1);

    // R6: disable gates irq; R7: write 0 to bit 9 keeps pending
    wr(8'h08, 32'h0000_0000);
    @(negedge clk);
    check("R6 irq gated", {127'b0, irq}, 128'b0);
    rd("R7 pending kept", 8'h08, v); check("R7 pend kept", {127'b0, v[9]}, 128'd1);
    wr(8'h08, 32'h0000_0300);
    rd("R7 cleared", 8'h08, v); check("R7 pend cleared", {127'b0, v[9]}, 128'b0);
    check("R6 irq low after clear", {127'b0, irq}, 128'b0);

    // R8: unknown code
    wr(8'h04, 32'h0000_02AB);
    rd("R8 status", 8'h00, v); check("R8 no busy", {127'b0, v[8]}, 128'b0);
    rd("R8 ics", 8'h08, v);
    check("R8 cause err", {120'b0, v[7:0]}, 128'd2);
    check("R8 pending", {127'b0, v[9]}, 128'd1);
    wr(8'h08, 32'h0000_0300);

    // R12/R11: subsystem 37 -> word 2 bits 11:10, via delayed mode
    wr(8'h28, 32'h0000_0800);
    wr(8'h04, 32'h0000_0401);
    rd("R11 delayed busy", 8'h00, v); check("R11 mode2 busy", {127'b0, v[8]}, 128'd1);
    // R10: command while busy ignored
    wr(8'h04, 32'h0000_02FF);
    rd("R10 cmd kept", 8'h04, v); check("R10 cmd value", {96'b0, v}, {96'b0, 32'h0000_0401});
    wait_idle();
    @(negedge clk);
    check("R12 subsystem 37", {126'b0, subsys_pwr[75:74]}, 128'd2);
    check("R12 subsystem 36", {126'b0, subsys_pwr[73:72]}, 128'd0);
    rd("R10 cause done", 8'h08, v); check("R10 cause 1", {120'b0, v[7:0]}, 128'd1);

    // R11: triggered mode; R7: completion wins over clear at the same edge
    wr(8'h08, 32'h0000_0300);
    wr(8'h2C, 32'h5555_AAAA);
    wr(8'h04, 32'h0000_0601);
    do @(negedge clk); while (!(m_busy && m_cnt == 1));
    wr(8'h08, 32'h0000_0300);
    rd("R7 set wins", 8'h08, v); check("R7 pend set wins", {127'b0, v[9]}, 128'd1);
    rd("R11 trig applied", 8'h3C, v); check("R11 sss3", {96'b0, v}, {96'b0, 32'h5555_AAAA});

    // R1: reset again clears everything
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    rd("R1 reset ics", 8'h08, v); check("R1 ics zero", {96'b0, v}, 128'b0);
    rd("R1 reset sss", 8'h3C, v); check("R1 sss zero", {96'b0, v}, 128'b0);
    check("R1 subsys zero", subsys_pwr, 128'b0);

    repeat (2) @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule